// File: doc/BRIEF.md
# ISA plug-and-play card configuration controller

This block is the card-side half of plug-and-play configuration on a simplified ISA I/O bus. The host reaches the card's configuration registers indirectly: it writes a register index to a fixed index port, then writes a value to a fixed write-data port or reads through a read-data port whose location the host chooses. The card moves through four states. In key-wait it watches for an unlock sequence. In sleep it waits to be woken. In isolation it takes part in a bit-by-bit contest on its serial identifier. In configuration the host programs it and reads its resource description.

The controller holds the card number that the host hands out after isolation, the selected logical device, and the read-port location. It also holds the pointers of the isolation contest and of the resource-byte stream. Control bits are one-shot: a write acts once and leaves nothing behind. A one-cycle `dev_reset` pulse tells the logical devices to restore their power-up configuration.

Top module: `pnp_card_cfg`

## Requirements
- R1: After reset the card is in key-wait (state code 0). The card number and device select are 0. The read-data port sits at I/O address 0x003, and the card drives nothing.
- R2: In key-wait, each write to the index port (0x279) is compared with the next unlock byte. The first byte is 0x6A, and each following byte is {k[1]^k[0], k[7:1]} of the one before. After 32 matches the card enters sleep (code 1). A mismatched byte restarts matching, and it counts as the first byte when it equals 0x6A. Writes to the write-data port (0xA79) are ignored in key-wait.
- R3: A wake write (index 0x03) acts only in sleep, and only when the byte equals the card number. Byte 0 enters isolation (code 2) and a nonzero byte enters configuration (code 3). The wake also rewinds the resource pointer, the ready delay and the isolation position.
- R4: In isolation, a read of index 0x01 takes part in the contest. Each identifier bit, least significant first from SERIAL_ID, uses two reads. A 1 bit drives 0x55 and then 0xAA. A 0 bit leaves the bus undriven, and `peer_drive` high during that read sends the card to sleep. After 72 bits, further reads are undriven and the card stays isolated.
- R5: A write of index 0x06 in isolation is taken only after all 72 bits; it stores the card number and enters configuration. In configuration, index 0x06 can be written and read back.
- R6: Writing bit 0 of index 0x02 gives a one-cycle `dev_reset` pulse and clears the device select. The card number and the state are kept.
- R7: Writing bit 1 of index 0x02 returns the card to key-wait with the card number kept, and unlock matching starts from its first byte.
- R8: Writing bit 2 of index 0x02 clears the card number. Index 0x02 keeps no bits: a read of it is undriven, and no pulse follows after the writing cycle.
- R9: In isolation or configuration, a write of index 0x00 moves the read-data port to address {data, 2'b11}. The old address then no longer answers, and a read of index 0x00 is undriven.
- R10: In configuration, index 0x04 returns the resource byte at the pointer. Bytes 0..8 are SERIAL_ID, low byte first. The last byte (RES_LEN-1) is 0x79, and byte i in between is 0x20+i. A read while bit 0 of index 0x05 is 1 advances the pointer (it holds at the last byte) and clears that bit for READY_LAT cycles. A read while the bit is 0 returns the same byte and does not advance.
- R11: In configuration, a write of index 0x07 takes effect only when the value is below N_DEV, and index 0x07 reads back the selection. A card with N_DEV=1 reads 0 and ignores every such write.
- R12: The card drives the read-data port only for an I/O read at the port address in isolation or configuration. In sleep, reads are undriven and writes of index 0x06 are ignored. In isolation, a wake is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | ADDR_W (12) | I/O address |
| io_wdata | input | 8 | Write data |
| peer_drive | input | 1 | Another card drives the bus during the current read |
| io_rdata | output | 8 | Read data (0 when not driving) |
| io_drive | output | 1 | Card drives io_rdata onto the bus this cycle |
| card_state | output | 2 | 0 key-wait, 1 sleep, 2 isolation, 3 configuration |
| card_num | output | 8 | Card number |
| dev_sel | output | DEV_W | Selected logical device |
| dev_reset | output | 1 | One-cycle logical-device reset pulse |

## Verification
The assertions watch the state graph on every cycle. Key-wait may only lead to sleep. A wake into isolation or configuration must agree with the card number held just before it. The card drives only during a port read in an active state, and the isolation pattern is 0x55 or 0xAA. The card number changes only after a write, and the reset pulse only follows a write-data access. The exact unlock sequence cannot be shown by a property, and neither can the order of identifier bits, the resource byte values with their ready delay, read-port relocation, or which registers each state ignores. The bench's scenarios cover these by comparing the card against its behavioural model on every clock.

// File: rtl/pnpc_pkg.sv
package pnpc_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_KEY = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } card_state_e;

    localparam logic [11:0] INDEX_PORT = 12'h279;
    localparam logic [11:0] WDATA_PORT = 12'hA79;

    localparam int KEY_LEN  = 32;
    localparam int ID_BITS  = 72;
    localparam int ID_BYTES = ID_BITS / 8;

    localparam logic [7:0] KEY_SEED = 8'h6A;
    localparam logic [7:0] END_TAG  = 8'h79;

    localparam logic [7:0] IDX_RDPORT = 8'h00;
    localparam logic [7:0] IDX_ISOL   = 8'h01;
    localparam logic [7:0] IDX_CTRL   = 8'h02;
    localparam logic [7:0] IDX_WAKE   = 8'h03;
    localparam logic [7:0] IDX_RES    = 8'h04;
    localparam logic [7:0] IDX_STAT   = 8'h05;
    localparam logic [7:0] IDX_NUM    = 8'h06;
    localparam logic [7:0] IDX_DEV    = 8'h07;

    // Unlock byte at position pos: seed, then shift right with XOR feedback
    function automatic logic [7:0] key_byte(input int pos);
        logic [7:0] k;
        k = KEY_SEED;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (i < pos) k = {k[1] ^ k[0], k[7:1]};
        end
        return k;
    endfunction

endpackage

// File: rtl/pnpc_key_match.sv
module pnpc_key_match
    import pnpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       unlock
);
    localparam int CNT_W = $clog2(KEY_LEN);

    logic [CNT_W-1:0] pos_q, pos_d;
    logic             hit;

    always_comb begin
        hit    = (byte_in == key_byte(int'(pos_q)));
        unlock = byte_vld && !restart && hit && (pos_q == CNT_W'(KEY_LEN - 1));
        pos_d  = pos_q;
        if (restart) begin
            pos_d = '0;
        end else if (byte_vld) begin
            if (hit) pos_d = (pos_q == CNT_W'(KEY_LEN - 1)) ? '0 : pos_q + 1'b1;
            else     pos_d = (byte_in == KEY_SEED) ? CNT_W'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/pnpc_iso_shift.sv
module pnpc_iso_shift
    import pnpc_pkg::*;
#(
    parameter logic [ID_BITS-1:0] SERIAL_ID = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       rd_strobe,
    input  logic       peer,
    output logic       drive,
    output logic [7:0] data,
    output logic       lose,
    output logic       done
);
    localparam int BIT_W = $clog2(ID_BITS + 1);

    typedef struct packed {
        logic [BIT_W-1:0] bit_pos;
        logic             second;
    } iso_t;

    iso_t q, d;
    logic cur_bit;

    always_comb begin
        done    = (q.bit_pos == BIT_W'(ID_BITS));
        cur_bit = done ? 1'b0 : SERIAL_ID[q.bit_pos];
        drive   = rd_strobe && !done && cur_bit;
        data    = q.second ? 8'hAA : 8'h55;
        lose    = rd_strobe && !done && !cur_bit && peer;
        d       = q;
        if (clear) begin
            d = '0;
        end else if (rd_strobe && !done) begin
            d.second = !q.second;
            if (q.second) d.bit_pos = q.bit_pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pnpc_res_rom.sv
module pnpc_res_rom
    import pnpc_pkg::*;
#(
    parameter int                 RES_LEN   = 16,
    parameter int                 READY_LAT = 2,
    parameter logic [ID_BITS-1:0] SERIAL_ID = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       rd_strobe,
    output logic [7:0] data,
    output logic       ready
);
    localparam int PTR_W  = $clog2(RES_LEN);
    localparam int WAIT_W = $clog2(READY_LAT + 1);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [WAIT_W-1:0] hold;
    } res_t;

    res_t q, d;
    int   p;

    always_comb begin
        p = int'(q.ptr);
        if (p < ID_BYTES)         data = SERIAL_ID[8*p +: 8];
        else if (p == RES_LEN - 1) data = END_TAG;
        else                       data = 8'h20 + 8'(p);
        ready = (q.hold == '0);
        d     = q;
        if (clear) begin
            d = '0;
        end else if (rd_strobe && ready) begin
            d.hold = WAIT_W'(READY_LAT);
            if (q.ptr != PTR_W'(RES_LEN - 1)) d.ptr = q.ptr + 1'b1;
        end else if (q.hold != '0) begin
            d.hold = q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pnp_card_cfg.sv
module pnp_card_cfg
    import pnpc_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter int                 N_DEV     = 2,
    parameter int                 RES_LEN   = 16,
    parameter int                 READY_LAT = 2,
    parameter logic [ID_BITS-1:0] SERIAL_ID = 72'h5A0123456789ABCDEF,
    localparam int                DEV_W     = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              peer_drive,
    output logic [7:0]        io_rdata,
    output logic              io_drive,
    output logic [1:0]        card_state,
    output logic [7:0]        card_num,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              dev_reset
);
    typedef struct packed {
        card_state_e      st;
        logic [7:0]       idx;
        logic [7:0]       rdp;
        logic [7:0]       num;
        logic [DEV_W-1:0] dev;
        logic             dev_rst;
    } ctl_t;

    ctl_t q, d;

    logic       wr_index, wr_data, rd_port;
    logic       ctrl_wr, to_wait, wake_hit;
    logic       iso_rd, res_rd, dev_ok;
    logic       unlock;
    logic       iso_drv, iso_lose, iso_done;
    logic [7:0] iso_data, res_data;
    logic       res_ready;

    always_comb begin
        wr_index = io_wr && (io_addr == ADDR_W'(INDEX_PORT));
        wr_data  = io_wr && (io_addr == ADDR_W'(WDATA_PORT)) && (q.st != ST_WAIT_KEY);
        rd_port  = io_rd && (io_addr == ADDR_W'({q.rdp, 2'b11}));
        ctrl_wr  = wr_data && (q.idx == IDX_CTRL);
        to_wait  = ctrl_wr && io_wdata[1];
        wake_hit = wr_data && (q.idx == IDX_WAKE) && (q.st == ST_SLEEP) && (io_wdata == q.num);
        iso_rd   = rd_port && (q.st == ST_ISOLATE) && (q.idx == IDX_ISOL);
        res_rd   = rd_port && (q.st == ST_CONFIG) && (q.idx == IDX_RES);
    end

    generate
        if (N_DEV > 1) begin : g_multi_dev
            assign dev_ok = (io_wdata < 8'(N_DEV));
        end else begin : g_single_dev
            assign dev_ok = 1'b0;
        end
    endgenerate

    pnpc_key_match u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (to_wait),
        .byte_vld (wr_index && (q.st == ST_WAIT_KEY)),
        .byte_in  (io_wdata),
        .unlock   (unlock)
    );

    pnpc_iso_shift #(.SERIAL_ID(SERIAL_ID)) u_iso (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wake_hit),
        .rd_strobe (iso_rd),
        .peer      (peer_drive),
        .drive     (iso_drv),
        .data      (iso_data),
        .lose      (iso_lose),
        .done      (iso_done)
    );

    pnpc_res_rom #(
        .RES_LEN   (RES_LEN),
        .READY_LAT (READY_LAT),
        .SERIAL_ID (SERIAL_ID)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wake_hit),
        .rd_strobe (res_rd),
        .data      (res_data),
        .ready     (res_ready)
    );

    // Next-state computation
    always_comb begin
        d         = q;
        d.dev_rst = 1'b0;
        if (wr_index && (q.st != ST_WAIT_KEY)) d.idx = io_wdata;
        if (unlock) d.st = ST_SLEEP;
        if (wr_data) begin
            unique case (q.idx)
                IDX_RDPORT: if (q.st == ST_ISOLATE || q.st == ST_CONFIG) d.rdp = io_wdata;
                IDX_CTRL: begin
                    if (io_wdata[0]) begin
                        d.dev_rst = 1'b1;
                        d.dev     = '0;
                    end
                    if (io_wdata[2]) d.num = '0;
                    if (io_wdata[1]) d.st  = ST_WAIT_KEY;
                end
                IDX_WAKE: if (wake_hit) d.st = (io_wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;
                IDX_NUM: begin
                    if (q.st == ST_CONFIG) begin
                        d.num = io_wdata;
                    end else if (q.st == ST_ISOLATE && iso_done) begin
                        d.num = io_wdata;
                        d.st  = ST_CONFIG;
                    end
                end
                IDX_DEV: if (q.st == ST_CONFIG && dev_ok) d.dev = io_wdata[DEV_W-1:0];
                default: ;
            endcase
        end
        if (iso_lose) d.st = ST_SLEEP;
    end

    // Read-data port
    always_comb begin
        io_drive = 1'b0;
        io_rdata = 8'h00;
        if (iso_rd) begin
            io_drive = iso_drv;
            io_rdata = iso_drv ? iso_data : 8'h00;
        end else if (rd_port && q.st == ST_CONFIG) begin
            unique case (q.idx)
                IDX_RES:  begin io_drive = 1'b1; io_rdata = res_data;              end
                IDX_STAT: begin io_drive = 1'b1; io_rdata = {7'b0, res_ready};     end
                IDX_NUM:  begin io_drive = 1'b1; io_rdata = q.num;                 end
                IDX_DEV:  begin io_drive = 1'b1; io_rdata = 8'(q.dev);             end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_WAIT_KEY;
        end else begin
            q <= d;
        end
    end

    assign card_state = q.st;
    assign card_num   = q.num;
    assign dev_sel    = q.dev;
    assign dev_reset  = q.dev_rst;
endmodule

// File: rtl/pnp_card_cfg_chk.sv
module pnp_card_cfg_chk
    import pnpc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_rdata,
    input logic              io_drive,
    input logic [1:0]        card_state,
    input logic [7:0]        card_num,
    input logic              dev_reset
);
    a_r2_wait_exits_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (card_state == ST_WAIT_KEY) |=> (card_state == ST_WAIT_KEY || card_state == ST_SLEEP));

    a_r3_isolate_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (card_state == ST_SLEEP) |=> (card_state != ST_ISOLATE || $past(card_num) == 8'h00));

    a_r3_config_needs_number: assert property (@(posedge clk) disable iff (!rst_n)
        (card_state == ST_SLEEP) |=> (card_state != ST_CONFIG || $past(card_num) != 8'h00));

    a_r4_isolation_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (io_drive && card_state == ST_ISOLATE) |-> (io_rdata == 8'h55 || io_rdata == 8'hAA));

    a_r5_number_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(card_num) |-> $past(io_wr));

    a_r6_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> $past(io_wr && io_addr == ADDR_W'(WDATA_PORT)));

    a_r12_drive_only_when_read: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive |-> (io_rd && (card_state == ST_ISOLATE || card_state == ST_CONFIG)));
endmodule

bind pnp_card_cfg pnp_card_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_addr    (io_addr),
    .io_rdata   (io_rdata),
    .io_drive   (io_drive),
    .card_state (card_state),
    .card_num   (card_num),
    .dev_reset  (dev_reset)
);

// File: tb/test_pnp_card_cfg.sv
module test_pnp_card_cfg;
    localparam int          N_DEV     = 2;
    localparam int          RES_LEN   = 16;
    localparam int          READY_LAT = 2;
    localparam logic [71:0] SID       = 72'h5A0123456789ABCDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        io_wr = 1'b0, io_rd = 1'b0, peer_drive = 1'b0;
    logic [11:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;

    logic [7:0] rdata_a, rdata_b, num_a, num_b;
    logic       drv_a, drv_b, drst_a, drst_b, dev_b;
    logic [1:0] st_a, st_b;
    logic [0:0] dev_a;

    pnp_card_cfg #(.N_DEV(N_DEV), .RES_LEN(RES_LEN), .READY_LAT(READY_LAT), .SERIAL_ID(SID)) i_pnp_card_cfg (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .peer_drive(peer_drive), .io_rdata(rdata_a), .io_drive(drv_a),
        .card_state(st_a), .card_num(num_a), .dev_sel(dev_a), .dev_reset(drst_a));

    pnp_card_cfg #(.N_DEV(1), .RES_LEN(RES_LEN), .READY_LAT(READY_LAT), .SERIAL_ID(SID)) i_pnp_card_cfg_solo (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .peer_drive(peer_drive), .io_rdata(rdata_b), .io_drive(drv_b),
        .card_state(st_b), .card_num(num_b), .dev_sel(dev_b), .dev_reset(drst_b));

    int    n_cmp = 0, n_bad = 0;
    string req = "R1";
    bit    finished = 0;
    bit [7:0] keyq[$];

    // Behavioural reference state
    int m_st = 0, m_idx = 0, m_rdp = 0, m_num = 0, m_dev = 0, m_drst = 0;
    int m_kc = 0, m_bit = 0, m_ph = 0, m_ptr = 0, m_wait = 0;

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int rom_exp(input int p);
        if (p < 9) return int'(SID[8*p +: 8]);
        if (p == RES_LEN - 1) return 'h79;
        return 'h20 + p;
    endfunction

    task automatic step(input bit wr, input bit rd, input int addr, input int wd, input bit peer);
        bit hit, iso_rd, res_rd;
        int ed, ev, ev1;
        @(negedge clk);
        chk("state", int'(st_a), m_st);
        chk("card number", int'(num_a), m_num);
        chk("device select", int'(dev_a), m_dev);
        chk("device reset", int'(drst_a), m_drst);
        chk("solo state", int'(st_b), m_st);
        chk("solo card number", int'(num_b), m_num);
        chk("solo device select", int'(dev_b), 0);
        io_wr = wr; io_rd = rd; io_addr = 12'(addr); io_wdata = 8'(wd); peer_drive = peer;
        #1;
        hit    = rd && (addr == m_rdp * 4 + 3);
        iso_rd = hit && m_st == 2 && m_idx == 1 && m_bit < 72;
        res_rd = hit && m_st == 3 && m_idx == 4;
        ed = 0; ev = 0;
        if (iso_rd && SID[m_bit]) begin ed = 1; ev = m_ph ? 'hAA : 'h55; end
        if (hit && m_st == 3) begin
            case (m_idx)
                4: begin ed = 1; ev = rom_exp(m_ptr); end
                5: begin ed = 1; ev = (m_wait == 0) ? 1 : 0; end
                6: begin ed = 1; ev = m_num; end
                7: begin ed = 1; ev = m_dev; end
                default: ;
            endcase
        end
        ev1 = (hit && m_st == 3 && m_idx == 7) ? 0 : ev;
        chk("drive", int'(drv_a), ed);
        chk("read data", int'(rdata_a), ev);
        chk("solo drive", int'(drv_b), ed);
        chk("solo read data", int'(rdata_b), ev1);
        // advance the model by one clock
        m_drst = 0;
        if (wr && addr == 'h279) begin
            if (m_st == 0) begin
                if (wd == int'(keyq[m_kc])) begin
                    m_kc++;
                    if (m_kc == 32) begin m_kc = 0; m_st = 1; end
                end else m_kc = (wd == int'(keyq[0])) ? 1 : 0;
            end else m_idx = wd;
        end else if (wr && addr == 'hA79 && m_st != 0) begin
            case (m_idx)
                0: if (m_st >= 2) m_rdp = wd;
                2: begin
                    if (wd % 2 == 1) begin m_drst = 1; m_dev = 0; end
                    if ((wd / 4) % 2 == 1) m_num = 0;
                    if ((wd / 2) % 2 == 1) begin m_st = 0; m_kc = 0; end
                end
                3: if (m_st == 1 && wd == m_num) begin
                    m_st = (wd == 0) ? 2 : 3;
                    m_ptr = 0; m_wait = 0; m_bit = 0; m_ph = 0;
                end
                6: if (m_st == 3) m_num = wd;
                   else if (m_st == 2 && m_bit >= 72) begin m_num = wd; m_st = 3; end
                7: if (m_st == 3 && wd < N_DEV) m_dev = wd;
                default: ;
            endcase
        end
        if (res_rd && m_wait == 0) begin
            m_wait = READY_LAT;
            if (m_ptr < RES_LEN - 1) m_ptr++;
        end else if (m_wait > 0) m_wait--;
        if (iso_rd) begin
            if (!SID[m_bit] && peer) m_st = 1;
            if (m_ph == 1) m_bit++;
            m_ph = 1 - m_ph;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask
    task automatic awr(input int v);  step(1, 0, 'h279, v, 0); endtask
    task automatic dwr(input int v);  step(1, 0, 'hA79, v, 0); endtask
    task automatic reg_wr(input int i, input int v); awr(i); dwr(v); endtask
    task automatic reg_rd(input int i, input bit peer);
        awr(i);
        step(0, 1, m_rdp * 4 + 3, 0, peer);
    endtask
    task automatic send_key();
        for (int i = 0; i < 32; i++) awr(int'(keyq[i]));
    endtask

    initial begin
        bit [7:0] k;
        k = 8'h6A;
        for (int i = 0; i < 32; i++) begin
            keyq.push_back(k);
            k = {k[1] ^ k[0], k[7:1]};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = "R1";  idle(3);
        step(0, 1, 'h003, 0, 0);
        req = "R2";  dwr('h55); reg_wr(6, 9); idle(1);
        for (int i = 0; i < 10; i++) awr(int'(keyq[i]));
        awr('h00);
        idle(1);
        send_key();
        idle(2);
        req = "R12"; reg_rd(6, 0); reg_wr(6, 'h33); idle(1);
        req = "R3";  reg_wr(3, 5); idle(1); reg_wr(3, 0); idle(1);
        req = "R9";  reg_wr(0, 'h80); step(0, 1, 'h003, 0, 0); idle(1);
        req = "R5";  reg_wr(6, 'h11); idle(1);
        req = "R12"; reg_wr(3, 0); idle(1);
        req = "R4";
        for (int i = 0; i < 144; i++) reg_rd(1, 0);
        reg_rd(1, 0); reg_rd(1, 0);
        req = "R5";  reg_wr(6, 7); idle(1); reg_rd(6, 0);
        req = "R10";
        for (int i = 0; i < 20; i++) begin
            reg_rd(5, 0);
            reg_rd(4, 0);
        end
        reg_rd(4, 0); reg_rd(4, 0); idle(3); reg_rd(5, 0);
        req = "R11"; reg_wr(7, 1); reg_rd(7, 0); reg_wr(7, 5); reg_rd(7, 0);
        req = "R9";  reg_rd(0, 0); step(0, 1, 'h003, 0, 0);
        req = "R8";  reg_rd(2, 0);
        req = "R6";  reg_wr(2, 1); idle(3); reg_rd(7, 0);
        req = "R7";  reg_wr(2, 2); idle(1); reg_wr(6, 'h44); send_key(); idle(1);
        req = "R3";  reg_wr(3, 7); idle(1); reg_rd(4, 0); reg_rd(6, 0);
        req = "R8";  reg_wr(2, 4); idle(3);
        req = "R7";  reg_wr(2, 2); send_key(); idle(1);
        req = "R4";  reg_wr(3, 0);
        for (int i = 0; i < 12; i++) reg_rd(1, 1);
        req = "R12"; reg_rd(6, 0); reg_wr(3, 9); idle(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule